// File: doc/BRIEF.md
# Adaptive Row-Buffer Close Timer

This block decides, bank by bank, whether a DRAM row stays open after an access and for how long. Each bank keeps an open flag, the address of the row it holds and a countdown. Every incoming access is compared against the stored row of its bank. The access is then labelled a row hit, a row miss or an access to a closed bank. One cycle later the block tells a downstream command sequencer which commands the access needs: precharge, activate and the column command. It also reports whether that column command should close the row itself, and the idle latency the access will see.

An idle row does not stay open for ever. The countdown is loaded when a row opens and reloaded with a longer value on every hit. When it runs out, the block raises a one-cycle precharge request for that bank. A locality monitor watches the most recent accesses. It moves a bank into close-page behaviour when too few of them reuse the previous row. A run of accesses to one row moves the bank back to open-page behaviour. A parameter selects one monitor per bank or a single monitor shared by the whole channel.

Top module: `rowbuf_page_ctl`

## Requirements
- R1: After reset, `acc_valid` and every `tmo_pre` bit are low. Every bank is closed, in open-page mode, with its stored row equal to 0. The first access to any bank is therefore classed closed, with `acc_autopre` low.
- R2: An access sampled with `req_valid` high at a clock edge produces `acc_valid` high after the next edge. At that point `acc_bank` and `acc_row` echo the request. `acc_class` is 0 (hit) when the bank is open and its stored row equals `req_row`, 1 (miss) when the bank is open with another row, and 2 (closed) when the bank is closed. A cycle without a request gives `acc_valid` low.
- R3: A hit asks for neither precharge nor activate. A miss asks for both. A closed access asks only for activate. A column command is implied in all three cases.
- R4: `acc_lat` is T_CAS for a hit, T_RP+T_RCD+T_CAS for a miss and T_RCD+T_CAS for a closed access.
- R5: An access that leaves its bank open after a closed or miss classification loads that bank's countdown with T_ACT. If that bank is not accessed again, its `tmo_pre` bit is high for exactly one cycle, T_ACT edges after the access edge, and the bank is then closed.
- R6: A hit that leaves the bank open reloads the countdown with T_HIT, which is larger than T_ACT. The timeout pulse then comes T_HIT edges after the hit edge.
- R7: An access to a bank in the same cycle that its countdown would expire suppresses that expiry. No `tmo_pre` pulse is raised for the bank, and a hit keeps the row open.
- R8: Each access to a bank records a locality sample. The sample is 1 when `req_row` equals the row of that bank's previous access, else 0. Once WIN samples have been collected in open-page mode since reset or since the last mode change, the access on which the last WIN samples satisfy hits*(T_RCD+T_RP) < WIN*T_RP switches the bank to close-page mode. That access already has `acc_autopre` high and leaves the bank closed.
- R9: In close-page mode every access has `acc_autopre` high, leaves the bank closed and loads no countdown.
- R10: In close-page mode, STREAK_N consecutive accesses that each repeat the previous row of that bank switch the bank back to open-page mode. The last of these has `acc_autopre` low and leaves the row open.
- R11: With SHARED_POLICY = 0, the mode of a bank depends only on accesses to that bank. With SHARED_POLICY = 1, one monitor fed by every access sets the mode of all banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_bank | input | BW | Bank index of the access |
| req_row | input | RW | Row address of the access |
| acc_valid | output | 1 | Classification result valid |
| acc_bank | output | BW | Bank of the classified access |
| acc_row | output | RW | Row of the classified access |
| acc_class | output | 2 | 0 hit, 1 miss, 2 closed bank |
| acc_pre | output | 1 | Precharge required before activate |
| acc_act | output | 1 | Activate required before the column command |
| acc_autopre | output | 1 | Column command closes the row itself |
| acc_lat | output | LW | Idle latency of the access in DRAM cycles |
| tmo_pre | output | NB | One-cycle precharge request per bank on countdown expiry |

## Verification
Every classification result is due exactly one edge after the edge that sampled the access. A timeout pulse is due T_ACT edges after the activating access, or T_HIT edges after the last hit. At each driven cycle the bench predicts the value of every output after the coming edge and queues that prediction. A monitor then wakes two nanoseconds after every rising edge and takes exactly one queued entry. Because of this, a result that comes one cycle early or late is compared against the wrong entry and is reported. The countdown suppression and the mode switches are placed on exact cycles, so the bench can check the cycle on which each one takes effect.

// File: rtl/rbp_pkg.sv
`timescale 1ns/1ps
package rbp_pkg;
   typedef enum logic [1:0] {
      CLS_HIT    = 2'd0,
      CLS_MISS   = 2'd1,
      CLS_CLOSED = 2'd2
   } acc_class_e;
endpackage

// File: rtl/rbp_locality_mon.sv
`timescale 1ns/1ps
// Locality monitor: sliding window of row-reuse samples plus a close-mode streak counter.
module rbp_locality_mon #(
   parameter int WIN      = 16,
   parameter int STREAK_N = 4,
   parameter int T_RP     = 3,
   parameter int T_RCD    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic same,
   output logic close_nxt
);
   localparam int FW = $clog2(WIN + 1);
   localparam int SW = $clog2(STREAK_N + 1);

   logic [WIN-1:0] hist_q, hist_n;
   logic [FW-1:0]  fill_q, fill_n;
   logic [SW-1:0]  streak_q, streak_n;
   logic           close_q;
   logic           go_close, go_open;
   int             hits_n;

   always_comb begin
      hist_n   = {hist_q[WIN-2:0], same};
      fill_n   = (fill_q == FW'(WIN)) ? fill_q : fill_q + FW'(1);
      hits_n   = $countones(hist_n);
      streak_n = (close_q && same) ?
                 ((streak_q == SW'(STREAK_N)) ? streak_q : streak_q + SW'(1)) : '0;
      go_close = !close_q && (fill_n == FW'(WIN)) &&
                 (hits_n * (T_RCD + T_RP) < WIN * T_RP);
      go_open  = close_q && (streak_n == SW'(STREAK_N));
      close_nxt = upd ? (go_close | (close_q & ~go_open)) : close_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q   <= '0;
         fill_q   <= '0;
         streak_q <= '0;
         close_q  <= 1'b0;
      end else if (upd) begin
         close_q <= close_nxt;
         if (go_close || go_open) begin
            hist_q   <= '0;
            fill_q   <= '0;
            streak_q <= '0;
         end else begin
            hist_q   <= hist_n;
            fill_q   <= fill_n;
            streak_q <= streak_n;
         end
      end
   end
endmodule

// File: rtl/rbp_bank_timer.sv
`timescale 1ns/1ps
// Per-bank open-row register and idle countdown.
module rbp_bank_timer #(
   parameter int RW    = 8,
   parameter int T_ACT = 8,
   parameter int T_HIT = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          keep_open,
   input  logic          is_hit,
   input  logic [RW-1:0] req_row,
   output logic          open_q,
   output logic [RW-1:0] row_q,
   output logic          tmo_q
);
   localparam int TW = $clog2(T_HIT + 1);

   logic [TW-1:0] tmr_q;
   logic          expire;

   assign expire = open_q && (tmr_q == TW'(1)) && !sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
         tmr_q  <= '0;
         tmo_q  <= 1'b0;
      end else begin
         tmo_q <= expire;
         if (sel) begin
            row_q <= req_row;
            if (keep_open) begin
               open_q <= 1'b1;
               tmr_q  <= is_hit ? TW'(T_HIT) : TW'(T_ACT);
            end else begin
               open_q <= 1'b0;
               tmr_q  <= '0;
            end
         end else if (expire) begin
            open_q <= 1'b0;
            tmr_q  <= '0;
         end else if (open_q) begin
            tmr_q <= tmr_q - TW'(1);
         end
      end
   end
endmodule

// File: rtl/rowbuf_page_ctl.sv
`timescale 1ns/1ps
module rowbuf_page_ctl #(
   parameter int NB            = 4,
   parameter int RW            = 8,
   parameter int T_RP          = 3,
   parameter int T_RCD         = 3,
   parameter int T_CAS         = 2,
   parameter int T_ACT         = 8,
   parameter int T_HIT         = 12,
   parameter int WIN           = 16,
   parameter int STREAK_N      = 4,
   parameter bit SHARED_POLICY = 1'b0,
   localparam int BW           = $clog2(NB),
   localparam int LW           = $clog2(T_RP + T_RCD + T_CAS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [BW-1:0] req_bank,
   input  logic [RW-1:0] req_row,
   output logic          acc_valid,
   output logic [BW-1:0] acc_bank,
   output logic [RW-1:0] acc_row,
   output logic [1:0]    acc_class,
   output logic          acc_pre,
   output logic          acc_act,
   output logic          acc_autopre,
   output logic [LW-1:0] acc_lat,
   output logic [NB-1:0] tmo_pre
);
   import rbp_pkg::*;

   if (NB < 2 || (1 << BW) != NB || T_ACT < 1 || T_HIT <= T_ACT ||
       WIN < 2 || STREAK_N < 1 || RW < 1) begin : g_param_bad
      $error("rowbuf_page_ctl: illegal parameter set");
   end

   logic          open_v [NB];
   logic [RW-1:0] row_v  [NB];
   logic [NB-1:0] close_nxt_v;
   logic          sel_open, same_row, hit, close_sel;
   acc_class_e    cls;
   logic [LW-1:0] lat_c;

   assign sel_open  = open_v[req_bank];
   assign same_row  = (req_row == row_v[req_bank]);
   assign hit       = sel_open && same_row;
   assign close_sel = close_nxt_v[req_bank];

   always_comb begin
      if (!sel_open)     cls = CLS_CLOSED;
      else if (same_row) cls = CLS_HIT;
      else               cls = CLS_MISS;
      case (cls)
         CLS_HIT:  lat_c = LW'(T_CAS);
         CLS_MISS: lat_c = LW'(T_RP + T_RCD + T_CAS);
         default:  lat_c = LW'(T_RCD + T_CAS);
      endcase
   end

   if (SHARED_POLICY) begin : g_chan_policy
      logic shared_nxt;
      rbp_locality_mon #(.WIN(WIN), .STREAK_N(STREAK_N), .T_RP(T_RP), .T_RCD(T_RCD)) u_mon (
         .clk(clk), .rst_n(rst_n), .upd(req_valid), .same(same_row), .close_nxt(shared_nxt));
      assign close_nxt_v = {NB{shared_nxt}};
   end else begin : g_bank_policy
      for (genvar b = 0; b < NB; b++) begin : g_mon
         rbp_locality_mon #(.WIN(WIN), .STREAK_N(STREAK_N), .T_RP(T_RP), .T_RCD(T_RCD)) u_mon (
            .clk(clk), .rst_n(rst_n),
            .upd(req_valid && (req_bank == BW'(b))),
            .same(same_row), .close_nxt(close_nxt_v[b]));
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      rbp_bank_timer #(.RW(RW), .T_ACT(T_ACT), .T_HIT(T_HIT)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .sel(req_valid && (req_bank == BW'(b))),
         .keep_open(!close_sel), .is_hit(hit), .req_row(req_row),
         .open_q(open_v[b]), .row_q(row_v[b]), .tmo_q(tmo_pre[b]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid   <= 1'b0;
         acc_bank    <= '0;
         acc_row     <= '0;
         acc_class   <= 2'd0;
         acc_pre     <= 1'b0;
         acc_act     <= 1'b0;
         acc_autopre <= 1'b0;
         acc_lat     <= '0;
      end else begin
         acc_valid <= req_valid;
         if (req_valid) begin
            acc_bank    <= req_bank;
            acc_row     <= req_row;
            acc_class   <= cls;
            acc_pre     <= (cls == CLS_MISS);
            acc_act     <= (cls != CLS_HIT);
            acc_autopre <= close_sel;
            acc_lat     <= lat_c;
         end
      end
   end
endmodule

// File: rtl/rbp_checker.sv
`timescale 1ns/1ps
module rbp_checker #(
   parameter int NB    = 4,
   parameter int RW    = 8,
   parameter int T_RP  = 3,
   parameter int T_RCD = 3,
   parameter int T_CAS = 2,
   localparam int BW   = $clog2(NB),
   localparam int LW   = $clog2(T_RP + T_RCD + T_CAS + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [BW-1:0] req_bank,
   input logic [RW-1:0] req_row,
   input logic          acc_valid,
   input logic [BW-1:0] acc_bank,
   input logic [RW-1:0] acc_row,
   input logic [1:0]    acc_class,
   input logic          acc_pre,
   input logic          acc_act,
   input logic [LW-1:0] acc_lat,
   input logic [NB-1:0] tmo_pre
);
   AST_ACC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> acc_valid && acc_bank == $past(req_bank) && acc_row == $past(req_row)); // R2
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !acc_valid); // R2
   AST_HIT_COL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_class == 2'd0 |-> !acc_pre && !acc_act); // R3
   AST_MISS_PRE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_class == 2'd1 |-> acc_pre && acc_act); // R3
   AST_MISS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_class == 2'd1 |-> acc_lat == LW'(T_RP + T_RCD + T_CAS)); // R4
   AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      |tmo_pre |=> (tmo_pre & $past(tmo_pre)) == '0); // R5
   AST_NO_TMO_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> !tmo_pre[acc_bank]); // R7
endmodule

bind rowbuf_page_ctl rbp_checker #(
   .NB(NB), .RW(RW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)
) u_chk (.*);

// File: tb/rowbuf_page_ctl_tb.sv
`timescale 1ns/1ps
module rowbuf_page_ctl_tb;
   localparam int NB = 4, RW = 8, T_RP = 3, T_RCD = 3, T_CAS = 2;
   localparam int T_ACT = 8, T_HIT = 12, WIN = 16, SN = 4;
   localparam int BW = $clog2(NB);
   localparam int LW = $clog2(T_RP + T_RCD + T_CAS + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [BW-1:0] req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic acc_valid, acc_pre, acc_act, acc_autopre;
   logic [BW-1:0] acc_bank;
   logic [RW-1:0] acc_row;
   logic [1:0] acc_class;
   logic [LW-1:0] acc_lat;
   logic [NB-1:0] tmo_pre;

   always #4 clk = ~clk;

   rowbuf_page_ctl #(.NB(NB), .RW(RW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_ACT(T_ACT), .T_HIT(T_HIT), .WIN(WIN), .STREAK_N(SN)) u_dut (.*);

   typedef struct {
      bit v; int cls; bit pre; bit act; bit ap; int lat; int bank; int row;
      bit [NB-1:0] tmo; string tag;
   } exp_t;
   exp_t q[$];

   int n_chk = 0, n_fail = 0;
   string scen = "R1";
   bit done = 1'b0;

   bit m_open[NB]; int m_row[NB]; int m_tmr[NB]; bit m_close[NB];
   bit [WIN-1:0] m_hist[NB]; int m_fill[NB]; int m_streak[NB];

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: drives one cycle and queues the predicted outputs after the next edge
   task automatic step(bit v, int b, int r);
      exp_t e;
      bit same, hit, goc, goo, nclose;
      int hits;
      @(negedge clk);
      req_valid = v; req_bank = BW'(b); req_row = RW'(r);
      e.v = v; e.tmo = '0; e.tag = scen; e.bank = b; e.row = r;
      e.cls = 0; e.pre = 0; e.act = 0; e.ap = 0; e.lat = 0;
      for (int bb = 0; bb < NB; bb++) begin
         if (!(v && bb == b)) begin
            if (m_open[bb] && m_tmr[bb] == 1) begin
               e.tmo[bb] = 1'b1; m_open[bb] = 0; m_tmr[bb] = 0;
            end else if (m_open[bb]) m_tmr[bb]--;
         end
      end
      if (v) begin
         same = (r == m_row[b]);
         hit = m_open[b] && same;
         e.cls = !m_open[b] ? 2 : (same ? 0 : 1);
         e.pre = (e.cls == 1);
         e.act = (e.cls != 0);
         e.lat = (e.cls == 0) ? T_CAS : (e.cls == 1) ? T_RP + T_RCD + T_CAS : T_RCD + T_CAS;
         m_hist[b] = {m_hist[b][WIN-2:0], same};
         if (m_fill[b] < WIN) m_fill[b]++;
         hits = $countones(m_hist[b]);
         m_streak[b] = (m_close[b] && same) ? ((m_streak[b] < SN) ? m_streak[b] + 1 : SN) : 0;
         goc = !m_close[b] && m_fill[b] == WIN && hits * (T_RCD + T_RP) < WIN * T_RP;
         goo = m_close[b] && m_streak[b] == SN;
         nclose = goc | (m_close[b] & !goo);
         if (goc || goo) begin m_hist[b] = '0; m_fill[b] = 0; m_streak[b] = 0; end
         m_close[b] = nclose;
         e.ap = nclose;
         if (nclose) begin m_open[b] = 0; m_tmr[b] = 0; end
         else begin m_open[b] = 1; m_tmr[b] = hit ? T_HIT : T_ACT; end
         m_row[b] = r;
      end
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   // monitor: one expectation per rising edge, sampled mid-cycle
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            chk(acc_valid == e.v, {"R2 valid ", e.tag}, acc_valid, e.v);
            if (e.v) begin
               chk(acc_bank == BW'(e.bank) && acc_row == RW'(e.row), {"R2 echo ", e.tag},
                   {acc_bank, acc_row}, (e.bank << RW) | e.row);
               chk(acc_class == 2'(e.cls), {"R2 class ", e.tag}, acc_class, e.cls);
               chk(acc_pre == e.pre && acc_act == e.act, {"R3 cmds ", e.tag},
                   {acc_pre, acc_act}, {e.pre, e.act});
               chk(acc_lat == LW'(e.lat), {"R4 latency ", e.tag}, acc_lat, e.lat);
               chk(acc_autopre == e.ap, {"R9 autopre ", e.tag}, acc_autopre, e.ap);
            end
            chk(tmo_pre == e.tmo, {"R5 timeout ", e.tag}, tmo_pre, e.tmo);
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NB; b++) begin
         m_open[b] = 0; m_row[b] = 0; m_tmr[b] = 0; m_close[b] = 0;
         m_hist[b] = '0; m_fill[b] = 0; m_streak[b] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      // R1: quiet outputs out of reset
      chk(acc_valid == 1'b0, "R1 reset valid", acc_valid, 0);
      chk(tmo_pre == '0, "R1 reset timeout", tmo_pre, 0);

      scen = "R1";          // first access to a fresh bank is closed, no autopre
      step(1, 0, 0);
      scen = "R3";          // hit then miss on bank 0
      step(1, 0, 0);
      step(1, 0, 7);
      scen = "R5";          // miss reloaded T_ACT; idle until the pulse
      idle(T_ACT + 2);

      scen = "R6";          // hit reload with the longer value
      step(1, 1, 4);
      step(1, 1, 4);
      idle(T_HIT + 2);

      scen = "R7";          // hit lands on the expiry cycle
      step(1, 2, 9);
      idle(T_ACT - 1);
      step(1, 2, 9);
      idle(T_HIT + 2);

      scen = "R8";          // poor locality on bank 3 flips it to close-page
      for (int i = 0; i < WIN; i++) step(1, 3, (i % 2) + 1);
      scen = "R11";         // bank 1 keeps open-page behaviour
      step(1, 1, 6);
      scen = "R9";          // close-page accesses on bank 3
      step(1, 3, 5);
      scen = "R10";         // same-row streak returns bank 3 to open-page
      for (int i = 0; i < SN; i++) step(1, 3, 5);
      step(1, 3, 5);
      scen = "R5";
      idle(T_HIT + 4);

      @(posedge clk); #3;
      done = 1'b1;
      chk(q.size() == 0, "R2 queue drained", q.size(), 0);
      summary();
      $finish;
   end
endmodule